// File: doc/BRIEF.md
# Serial Flash Command Responder

This block is the control side of a serial flash memory, reduced to three commands: setting the write-enable latch, erasing the whole chip and reading the status byte. An SPI host reaches it through four pins: select (active low), serial clock, data in and data out. The data-out pin has a separate enable so that the pad can float it. The block oversamples the pins with its own system clock. It accepts hosts that idle the serial clock either low (mode 0) or high (mode 3).

A chip erase runs on an internal cycle counter. While the counter runs, the busy bit in the status byte stays set. When it finishes, the modelled array reads as all ones and a one-clock `erase_done` pulse appears on the sideband. The block-protect field comes in on the sideband port and is reported in the status byte. If any protect bit is set, a chip erase is refused.

The interface is a state machine with six states:
- `ST_IDLE`: select is high.
- `ST_CMD`: the opcode is being shifted in.
- `ST_STATUS`: the status byte is being streamed out.
- `ST_ARM_WEL`: a write-enable opcode is waiting for select to rise.
- `ST_ARM_ERASE`: an erase opcode is waiting for select to rise.
- `ST_DISCARD`: the command is dropped until select rises.

Its transitions are:
- `ST_IDLE` goes to `ST_CMD` on select low.
- `ST_CMD` goes to one of `ST_STATUS`, `ST_ARM_WEL`, `ST_ARM_ERASE` or `ST_DISCARD` once the eighth bit has been received.
- Any state returns to `ST_IDLE` on a rising select.
- The two armed states go to `ST_DISCARD` on an extra rising clock edge.

Top module: `flash_cmd_responder`

## Requirements
- R1: Opcodes are 8 bits, sampled on rising serial-clock edges while select is low, most significant bit first. A host that idles the clock low and a host that idles it high are both served.
- R2: Opcode 0x06, followed by select rising right after the eighth bit, sets the write-enable latch, which is status bit 1.
- R3: Opcode 0x60 or 0xC7, with the latch set and the protect field at zero, starts an erase when select rises. Status bit 0 (busy) is then set for ERASE_CYCLES clocks. After that, `erase_done` pulses for one clock and both the busy bit and the latch clear.
- R4: An erase opcode issued with the latch clear has no effect. No busy bit is set and no `erase_done` pulse appears.
- R5: An erase opcode issued while `blk_protect` is nonzero starts no erase and clears the latch.
- R6: Opcode 0x05 makes SO shift the status byte out MSB first, starting on the falling clock edge after the opcode. The byte is {4'b0000, blk_protect[1:0], latch, busy}. It repeats every 8 clocks until select rises, and this command works while an erase is running.
- R7: `spi_so_en` is low whenever no status byte is being streamed, including from reset and after select has risen.
- R8: A select rise before eight bits have been received aborts the command with no effect.
- R9: While an erase runs, every opcode other than 0x05 is ignored. A write-enable or a second erase sent at that time changes nothing.
- R10: An unknown opcode has no effect. Extra rising clock edges after a 0x06 or erase opcode, before select rises, cancel that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial status data to the host |
| spi_so_en | output | 1 | Drive enable for spi_so; low means the pin floats |
| blk_protect | input | 2 | Block-protect field; any nonzero value forbids erase |
| erase_done | output | 1 | One-clock pulse when a chip erase completes |

## Verification
The bench builds the block with ERASE_CYCLES = 1000 and SYNC_STAGES = 2. That erase length is long enough for status reads, a write-enable and a second erase to be issued while busy is still set. It is also short enough for the exact busy length to be checked, and for a full extra erase period to pass afterwards with no second completion. The bench holds each serial clock phase for six system clocks, which stays safely above the synchronizer and edge-detect latency.

// File: rtl/flash_resp_pkg.sv
package flash_resp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_STATUS,
        ST_ARM_WEL,
        ST_ARM_ERASE,
        ST_DISCARD
    } resp_state_t;

    localparam logic [7:0] OP_WREN    = 8'h06;
    localparam logic [7:0] OP_RDSR    = 8'h05;
    localparam logic [7:0] OP_ERASE_A = 8'h60;
    localparam logic [7:0] OP_ERASE_B = 8'hC7;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic cs_n_in,
    input  logic si_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_high,
    output logic cs_rise,
    output logic si_s
);
    localparam int PW = 3;

    logic [SYNC_STAGES-1:0][PW-1:0] chain_q;
    logic [PW-1:0] tail;
    logic          sck_prev_q;
    logic          cs_prev_q;

    assign tail = chain_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q    <= {SYNC_STAGES{3'b100}};
            sck_prev_q <= 1'b0;
            cs_prev_q  <= 1'b1;
        end else begin
            chain_q    <= {chain_q[SYNC_STAGES-2:0], {cs_n_in, sck_in, si_in}};
            sck_prev_q <= tail[1];
            cs_prev_q  <= tail[2];
        end
    end

    assign cs_high  = tail[2];
    assign cs_rise  = tail[2] & ~cs_prev_q;
    assign sck_rise = tail[1] & ~sck_prev_q;
    assign sck_fall = ~tail[1] & sck_prev_q;
    assign si_s     = tail[0];

endmodule

// File: rtl/cmd_shifter.sv
module cmd_shifter #(
    parameter int CMD_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                shift_en,
    input  logic                din,
    output logic [CMD_BITS-1:0] data,
    output logic                byte_done
);
    localparam int CNT_W = $clog2(CMD_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_BITS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            data      <= '0;
            byte_done <= 1'b0;
        end else if (clear) begin
            cnt_q     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= shift_en && (cnt_q == LAST);
            if (shift_en) begin
                data  <= {data[CMD_BITS-2:0], din};
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
    parameter int ERASE_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(ERASE_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (cnt_q == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (start) begin
                busy  <= 1'b1;
                cnt_q <= CW'(ERASE_CYCLES - 1);
            end
        end
    end

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));                                      // R3
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);                                                      // R9

endmodule

// File: rtl/flash_cmd_responder.sv
module flash_cmd_responder
    import flash_resp_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int ERASE_CYCLES = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic       spi_si,
    output logic       spi_so,
    output logic       spi_so_en,
    input  logic [1:0] blk_protect,
    output logic       erase_done
);
    localparam int CMD_BITS = 8;
    localparam int IDX_W    = $clog2(CMD_BITS);

    logic                sck_rise, sck_fall, cs_high, cs_rise, si_s;
    logic [CMD_BITS-1:0] opcode;
    logic                byte_done;
    logic                erase_busy;
    logic                wel_q;
    logic                wel_set, erase_go, erase_reject;
    logic [CMD_BITS-1:0] status;
    logic [IDX_W-1:0]    bit_idx_q;
    logic                so_bit_q;
    resp_state_t         state_q, state_d;

    spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sck_in(spi_sck), .cs_n_in(spi_cs_n), .si_in(spi_si),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_high(cs_high), .cs_rise(cs_rise), .si_s(si_s)
    );

    cmd_shifter #(.CMD_BITS(CMD_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .clear(cs_high), .shift_en(sck_rise), .din(si_s),
        .data(opcode), .byte_done(byte_done)
    );

    erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .start(erase_go), .busy(erase_busy), .done(erase_done)
    );

    assign status = {4'b0000, blk_protect, wel_q, erase_busy};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and command strobes
    always_comb begin
        state_d      = state_q;
        wel_set      = 1'b0;
        erase_go     = 1'b0;
        erase_reject = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_high) state_d = ST_CMD;
            end
            ST_CMD: begin
                if (cs_rise) begin
                    state_d = ST_IDLE;
                end else if (byte_done) begin
                    if (opcode == OP_RDSR)                              state_d = ST_STATUS;
                    else if (erase_busy)                                state_d = ST_DISCARD;
                    else if (opcode == OP_WREN)                         state_d = ST_ARM_WEL;
                    else if (opcode == OP_ERASE_A || opcode == OP_ERASE_B) state_d = ST_ARM_ERASE;
                    else                                                state_d = ST_DISCARD;
                end
            end
            ST_STATUS: begin
                if (cs_rise) state_d = ST_IDLE;
            end
            ST_ARM_WEL: begin
                if (cs_rise) begin
                    state_d = ST_IDLE;
                    wel_set = 1'b1;
                end else if (sck_rise) begin
                    state_d = ST_DISCARD;
                end
            end
            ST_ARM_ERASE: begin
                if (cs_rise) begin
                    state_d = ST_IDLE;
                    if (wel_q && blk_protect == 2'b00 && !erase_busy) erase_go = 1'b1;
                    else                                             erase_reject = 1'b1;
                end else if (sck_rise) begin
                    state_d = ST_DISCARD;
                end
            end
            ST_DISCARD: begin
                if (cs_rise) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // write-enable latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         wel_q <= 1'b0;
        else if (erase_done || erase_reject) wel_q <= 1'b0;
        else if (wel_set)                   wel_q <= 1'b1;
    end

    // outputs: status serializer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx_q <= IDX_W'(CMD_BITS - 1);
            so_bit_q  <= 1'b0;
        end else if (state_q != ST_STATUS) begin
            bit_idx_q <= IDX_W'(CMD_BITS - 1);
            so_bit_q  <= 1'b0;
        end else if (sck_fall) begin
            so_bit_q  <= status[bit_idx_q];
            bit_idx_q <= bit_idx_q - 1'b1;
        end
    end

    assign spi_so    = so_bit_q;
    assign spi_so_en = (state_q == ST_STATUS);

    AST_SO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_so_en && cs_high) |=> !spi_so_en);                                // R7
    AST_ERASE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_busy) |-> ($past(wel_q) && $past(blk_protect) == 2'b00));  // R3
    AST_WEL_NOT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> !$past(erase_busy));                                  // R9
    AST_STREAM_ON_RDSR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_so_en) |-> ($past(opcode) == OP_RDSR));                      // R6

endmodule

// File: tb/test_flash_cmd_responder.sv
module test_flash_cmd_responder;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int ERASE_CYC  = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic [1:0] prot = 2'b00;
    logic       so, so_en, erase_done;

    int n_checks = 0, n_err = 0;
    int cycle = 0;
    int done_q[$];
    int t_erase = 0;
    int cs_hi_cnt = 0;
    bit prev_done = 1'b0;
    bit m_wel = 1'b0;
    bit m_busy = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_responder #(.SYNC_STAGES(2), .ERASE_CYCLES(ERASE_CYC)) i_flash_cmd_responder (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
        .spi_so(so), .spi_so_en(so_en), .blk_protect(prot), .erase_done(erase_done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-clock monitor
    always @(negedge clk) begin
        cycle++;
        if (rst_n) begin
            if (erase_done) done_q.push_back(cycle);
            if (prev_done && erase_done) check("R3 done pulse width", 1, 0);
            prev_done = erase_done;
            cs_hi_cnt = cs_n ? cs_hi_cnt + 1 : 0;
            if (cs_hi_cnt >= 6) check("R7 so_en idle", int'(so_en), 0);
        end
    end

    function automatic logic [7:0] exp_status();
        return {4'b0000, prot, m_wel, m_busy};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin(input bit mode3);
        sck = mode3;
        wait_clk(HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_end();
        wait_clk(HALF);
        cs_n = 1'b1;
        t_erase = cycle;
        wait_clk(2 * HALF);
    endtask

    task automatic spi_bits(input bit mode3, input logic [7:0] tx, input int nbits,
                            output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (mode3) sck = 1'b0;
            si = tx[i];
            wait_clk(HALF);
            rx[i] = so;
            sck = 1'b1;
            wait_clk(HALF);
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic send_cmd(input bit mode3, input logic [7:0] op);
        logic [7:0] rx;
        cs_begin(mode3);
        spi_bits(mode3, op, 8, rx);
        cs_end();
    endtask

    task automatic read_status(input bit mode3, input string req);
        logic [7:0] rx, b0, b1;
        cs_begin(mode3);
        spi_bits(mode3, 8'h05, 8, rx);
        check({req, " so_en during stream"}, int'(so_en), 1);
        spi_bits(mode3, 8'h00, 8, b0);
        spi_bits(mode3, 8'h00, 8, b1);
        cs_end();
        check({req, " status byte"}, int'(b0), int'(exp_status()));
        check({req, " status repeat R6"}, int'(b1), int'(exp_status()));
        check({req, " so_en released R7"}, int'(so_en), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        wait_clk(5);
        check("R7 reset so_en", int'(so_en), 0);
        check("R3 reset erase_done", int'(erase_done), 0);
        rst_n = 1'b1;
        wait_clk(10);

        read_status(1'b0, "R6 idle mode0");
        send_cmd(1'b0, 8'h06); m_wel = 1'b1;
        read_status(1'b0, "R2 R1 wren mode0");

        // R8: partial erase opcode
        cs_begin(1'b0); spi_bits(1'b0, 8'h60, 5, rx); cs_end();
        wait_clk(ERASE_CYC / 10);
        read_status(1'b0, "R8 aborted");
        check("R8 no erase", done_q.size(), 0);

        // R5: protected
        prot = 2'b01;
        read_status(1'b0, "R6 protect bits");
        send_cmd(1'b0, 8'hC7); m_wel = 1'b0;
        wait_clk(ERASE_CYC / 10);
        read_status(1'b0, "R5 protected reject");
        check("R5 no erase", done_q.size(), 0);
        prot = 2'b10;
        read_status(1'b1, "R6 protect high bit mode3");
        prot = 2'b00;

        // R4: no latch
        send_cmd(1'b0, 8'h60);
        wait_clk(ERASE_CYC / 10);
        read_status(1'b0, "R4 no wel");
        check("R4 no erase", done_q.size(), 0);

        // R10: unknown opcode and trailing clocks
        send_cmd(1'b1, 8'h06); m_wel = 1'b1;
        read_status(1'b1, "R1 R2 wren mode3");
        send_cmd(1'b0, 8'hA5);
        read_status(1'b0, "R10 unknown opcode");
        cs_begin(1'b0); spi_bits(1'b0, 8'h60, 8, rx); spi_bits(1'b0, 8'h00, 3, rx); cs_end();
        wait_clk(ERASE_CYC / 10);
        read_status(1'b0, "R10 trailing clocks");
        check("R10 no erase", done_q.size(), 0);

        // R3 with 0xC7 in mode3, then R9 while busy
        send_cmd(1'b1, 8'hC7); m_busy = 1'b1;
        begin
            int t0;
            t0 = t_erase;
            read_status(1'b1, "R3 R6 busy read");
            send_cmd(1'b0, 8'h06);
            send_cmd(1'b0, 8'h60);
            for (int k = 0; k < 3 * ERASE_CYC && done_q.size() == 0; k++) wait_clk(1);
            check("R3 erase completed", done_q.size(), 1);
            if (done_q.size() > 0) begin
                check("R3 busy length lower", int'(done_q[0] - t0 >= ERASE_CYC), 1);
                check("R3 busy length upper", int'(done_q[0] - t0 <= ERASE_CYC + 10), 1);
            end
        end
        m_busy = 1'b0; m_wel = 1'b0;
        wait_clk(4);
        read_status(1'b0, "R3 R9 after erase");
        wait_clk(ERASE_CYC + 50);
        check("R9 no second erase", done_q.size(), 1);

        // R3 with 0x60 in mode0
        send_cmd(1'b0, 8'h06); m_wel = 1'b1;
        send_cmd(1'b0, 8'h60); m_busy = 1'b1;
        read_status(1'b0, "R3 busy 0x60");
        for (int k = 0; k < 3 * ERASE_CYC && done_q.size() < 2; k++) wait_clk(1);
        check("R3 second erase done", done_q.size(), 2);
        m_busy = 1'b0; m_wel = 1'b0;
        wait_clk(4);
        read_status(1'b1, "R3 final status");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule